// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block decides whether an I2C slave should answer the address phase of a transfer. A bit-level front end hands it whole received bytes with a one-cycle valid strobe. It also passes on bus events as one-cycle pulses: start, repeated start and stop. The matcher checks the first byte after a start against a programmed address. In 10-bit mode it also checks the byte that follows. When the address fits, it raises a one-cycle match pulse. It also keeps the read/write bit of the address byte.

Two addressing modes are supported. In 7-bit mode, bits 7:1 of the first byte hold the address. In 10-bit mode, a high byte comes first. Its bits 7:3 must carry the fixed prefix 11110, and that prefix is checked by fixed logic. The low byte then follows. A per-bit mask drops chosen address bits from the comparison, and a masked bit always counts as equal. Once a full 10-bit match has been made, a repeated start followed by a matching high byte that requests a read is accepted without a new low byte.

The high-byte and 7-bit reference come from `addrMain`, and the 10-bit low-byte reference comes from `addrLow`. The `expectLow` output shows that the next byte will be compared as the low byte.

Top module: `i2c_addr_match`

## Requirements
- R1: While `rstN` is low and right after it is released, `matchPulse`, `rwFlag` and `expectLow` are 0.
- R2: With `tenBitMode`=0, the first byte after a start or repeated start matches when its bits 7:1 equal `addrMain[7:1]` at every position whose `maskBits` bit is 1. `addrMain[0]` and `maskBits[0]` have no effect.
- R3: A `maskBits` bit of 0 makes the corresponding received bit count as equal whatever its value.
- R4: With `tenBitMode`=1, the first byte after a start is a high-byte hit only if its bits 7:3 are 11110 and its bits 2:1 equal `addrMain[2:1]` under `maskBits[2:1]`. This holds regardless of `addrMain[7:3]`. A hit with bit 0 = 0 (write) sets `expectLow` to 1 in the cycle after the valid strobe.
- R5: While `expectLow` is 1, the next byte matches when all eight bits equal `addrLow` under `maskBits`. This includes bit 0, which is gated by `maskBits[0]`.
- R6: `rwFlag` takes bit 0 of the first byte after each start or repeated start, in the cycle after its valid strobe. Otherwise it holds its value.
- R7: `matchPulse` is 1 for exactly the one cycle after the valid strobe of the deciding byte. That byte is the 7-bit address byte, the 10-bit low byte, or the high byte in the resume case of R10.
- R8: A byte that arrives before any start, or after the address phase has been decided, produces no match and leaves `rwFlag` and `expectLow` unchanged.
- R9: A mismatching address byte or low byte returns the block to idle. `expectLow` is 0 afterwards, and later bytes produce no match until the next start.
- R10: After a full 10-bit match, a repeated start followed by a high-byte hit with bit 0 = 1 (read) produces a match. A plain start, a stop, a failed byte or a new high byte in write direction cancels this resume right. A read high byte without the resume right produces no match.
- R11: A stop clears `expectLow` and the resume right. It takes priority over a start or byte in the same cycle.
- R12: A byte strobed in the same cycle as a start or repeated start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | One-cycle strobe qualifying rxByte |
| startEv | input | 1 | Start condition pulse |
| restartEv | input | 1 | Repeated start pulse |
| stopEv | input | 1 | Stop condition pulse |
| tenBitMode | input | 1 | 1 selects 10-bit addressing |
| addrMain | input | 8 | 7-bit address in bits 7:1, or 10-bit high bits in 2:1 |
| addrLow | input | 8 | Eight low bits of the 10-bit address |
| maskBits | input | 8 | Per-bit compare enable (1 = compare) |
| matchPulse | output | 1 | One-cycle address match |
| rwFlag | output | 1 | Captured read/write bit |
| expectLow | output | 1 | Next byte is the 10-bit low byte |

## Verification
The hardest state to reach is the resume right of the 10-bit read path. It exists only after a full write-direction 10-bit match, and any stop, plain start or failed byte destroys it. The stimulus therefore builds a complete high-plus-low match first and then issues a repeated start with a read high byte. It then repeats the same read byte after a plain start, after a stop and with no prior match, so each way of losing the right is seen. Collisions of events with bytes in the same cycle (stop with a byte, start with a byte) are driven on purpose to exercise the priority rules.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;
  localparam int BYTE_W = 8;
  localparam int PREFIX_W = 5;
  localparam logic [PREFIX_W-1:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_LOW  = 2'd2
  } phase_t;

  typedef struct packed {
    logic captureRw;
    logic fireMatch;
    logic setResume;
    logic clrResume;
  } ctlStrobes_t;
endpackage

// File: rtl/i2c_addr_match_dp.sv
module i2c_addr_match_dp
  import i2c_addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [BYTE_W-1:0] addrMain,
  input  logic [BYTE_W-1:0] addrLow,
  input  logic [BYTE_W-1:0] maskBits,
  input  logic              selLow,
  input  ctlStrobes_t       ctl,
  output logic              sevenHit,
  output logic              highHit,
  output logic              lowHit,
  output logic              rxRw,
  output logic              resumeOk,
  output logic              matchPulse,
  output logic              rwFlag
);
  localparam int PREFIX_LSB = BYTE_W - PREFIX_W;

  logic [BYTE_W-1:0] refByte;
  logic [BYTE_W-1:0] bitMiss;

  assign refByte = selLow ? addrLow : addrMain;

  // per-bit masked miss
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign bitMiss[i] = (rxByte[i] ^ refByte[i]) & maskBits[i];
  end

  assign sevenHit = ~|bitMiss[BYTE_W-1:1];
  assign highHit  = (rxByte[BYTE_W-1:PREFIX_LSB] == TEN_PREFIX) &&
                    ~|bitMiss[PREFIX_LSB-1:1];
  assign lowHit   = ~|bitMiss;
  assign rxRw     = rxByte[0];

  logic resumeQ, matchQ, rwQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resumeQ <= 1'b0;
      matchQ  <= 1'b0;
      rwQ     <= 1'b0;
    end else begin
      matchQ <= ctl.fireMatch;
      if (ctl.captureRw) rwQ <= rxByte[0];
      if (ctl.clrResume) resumeQ <= 1'b0;
      else if (ctl.setResume) resumeQ <= 1'b1;
    end
  end

  assign resumeOk   = resumeQ;
  assign matchPulse = matchQ;
  assign rwFlag     = rwQ;
endmodule

// File: rtl/i2c_addr_match_ctl.sv
module i2c_addr_match_ctl
  import i2c_addr_match_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        startEv,
  input  logic        restartEv,
  input  logic        stopEv,
  input  logic        tenBitMode,
  input  logic        sevenHit,
  input  logic        highHit,
  input  logic        lowHit,
  input  logic        rxRw,
  input  logic        resumeOk,
  output ctlStrobes_t ctl,
  output logic        selLow
);
  phase_t phase, phaseNxt;

  always_comb begin
    phaseNxt = phase;
    ctl      = '0;
    if (stopEv) begin
      phaseNxt      = ST_IDLE;
      ctl.clrResume = 1'b1;
    end else if (startEv || restartEv) begin
      phaseNxt      = ST_ADDR;
      ctl.clrResume = startEv;
    end else if (rxValid) begin
      unique case (phase)
        ST_ADDR: begin
          ctl.captureRw = 1'b1;
          phaseNxt      = ST_IDLE;
          if (!tenBitMode) begin
            ctl.fireMatch = sevenHit;
          end else if (highHit && !rxRw) begin
            phaseNxt      = ST_LOW;
            ctl.clrResume = 1'b1;
          end else if (highHit && resumeOk) begin
            ctl.fireMatch = 1'b1;
          end else begin
            ctl.clrResume = 1'b1;
          end
        end
        ST_LOW: begin
          phaseNxt      = ST_IDLE;
          ctl.fireMatch = lowHit;
          ctl.setResume = lowHit;
        end
        default: phaseNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNxt;
  end

  assign selLow = (phase == ST_LOW);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       startEv,
  input  logic       restartEv,
  input  logic       stopEv,
  input  logic       tenBitMode,
  input  logic [7:0] addrMain,
  input  logic [7:0] addrLow,
  input  logic [7:0] maskBits,
  output logic       matchPulse,
  output logic       rwFlag,
  output logic       expectLow
);
  ctlStrobes_t ctl;
  logic selLow, sevenHit, highHit, lowHit, rxRw, resumeOk;

  i2c_addr_match_ctl u_ctl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .startEv(startEv),
    .restartEv(restartEv), .stopEv(stopEv), .tenBitMode(tenBitMode),
    .sevenHit(sevenHit), .highHit(highHit), .lowHit(lowHit), .rxRw(rxRw),
    .resumeOk(resumeOk), .ctl(ctl), .selLow(selLow)
  );

  i2c_addr_match_dp u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .addrMain(addrMain),
    .addrLow(addrLow), .maskBits(maskBits), .selLow(selLow), .ctl(ctl),
    .sevenHit(sevenHit), .highHit(highHit), .lowHit(lowHit), .rxRw(rxRw),
    .resumeOk(resumeOk), .matchPulse(matchPulse), .rwFlag(rwFlag)
  );

  assign expectLow = selLow;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] rxByte,
  input logic       rxValid,
  input logic       startEv,
  input logic       restartEv,
  input logic       stopEv,
  input logic       matchPulse,
  input logic       rwFlag,
  input logic       expectLow
);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  p_match_after_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(rxValid));

  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (!expectLow && !matchPulse));

  p_rw_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(rwFlag));

  p_low_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(expectLow) |-> ($past(rxValid) && $past(rxByte[7:3]) == 5'b11110
                          && !$past(rxByte[0])));

  p_event_byte_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (startEv || restartEv)) |=> !matchPulse);
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
  .startEv(startEv), .restartEv(restartEv), .stopEv(stopEv),
  .matchPulse(matchPulse), .rwFlag(rwFlag), .expectLow(expectLow)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic rxValid = 1'b0, startEv = 1'b0, restartEv = 1'b0, stopEv = 1'b0;
  logic tenBitMode = 1'b0;
  logic [7:0] addrMain = 8'h00, addrLow = 8'h00, maskBits = 8'hFF;
  logic matchPulse, rwFlag, expectLow;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference model state
  int  mPhase = 0;  // 0 idle, 1 expect address, 2 expect low byte
  bit  mResume = 0;
  bit  mMatch = 0;
  bit  mRw = 0;
  int  matchCount = 0;

  always #10 clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .startEv(startEv), .restartEv(restartEv), .stopEv(stopEv),
    .tenBitMode(tenBitMode), .addrMain(addrMain), .addrLow(addrLow),
    .maskBits(maskBits), .matchPulse(matchPulse), .rwFlag(rwFlag),
    .expectLow(expectLow)
  );

  function automatic bit eqMasked(int a, int b, int m, int lo, int hi);
    for (int i = lo; i <= hi; i++)
      if (((m >> i) & 1) == 1 && ((a >> i) & 1) != ((b >> i) & 1)) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 0; mResume <= 0; mMatch <= 0; mRw <= 0;
    end else begin
      mMatch <= 0;
      if (stopEv) begin
        mPhase <= 0; mResume <= 0;
      end else if (startEv || restartEv) begin
        mPhase <= 1;
        if (startEv) mResume <= 0;
      end else if (rxValid && mPhase == 1) begin
        mRw <= rxByte[0];
        mPhase <= 0;
        if (!tenBitMode) begin
          mMatch <= eqMasked(rxByte, addrMain, maskBits, 1, 7);
        end else begin
          automatic bit hi = (rxByte[7:3] == 5'b11110) &&
                             eqMasked(rxByte, addrMain, maskBits, 1, 2);
          if (hi && !rxByte[0]) begin mPhase <= 2; mResume <= 0; end
          else if (hi && mResume) mMatch <= 1;
          else mResume <= 0;
        end
      end else if (rxValid && mPhase == 2) begin
        mPhase <= 0;
        if (eqMasked(rxByte, addrLow, maskBits, 0, 7)) begin
          mMatch <= 1; mResume <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (matchPulse !== mMatch || rwFlag !== mRw || expectLow !== (mPhase == 2)) begin
      fails++;
      $display("FAIL %s: match/rw/expectLow actual %b%b%b expected %b%b%b", curReq,
               matchPulse, rwFlag, expectLow, mMatch, mRw, mPhase == 2);
    end
    if (matchPulse === 1'b1) matchCount++;
  end

  task automatic tick();
    @(negedge clk);
    rxValid = 0; startEv = 0; restartEv = 0; stopEv = 0;
  endtask
  task automatic doStart(); @(negedge clk); startEv = 1; tick(); endtask
  task automatic doRestart(); @(negedge clk); restartEv = 1; tick(); endtask
  task automatic doStop(); @(negedge clk); stopEv = 1; tick(); endtask
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxByte = b; rxValid = 1; tick();
  endtask
  task automatic expectCount(input string req, input int exp);
    checks++;
    if (matchCount != exp) begin
      fails++;
      $display("FAIL %s: match count actual %0d expected %0d", req, matchCount, exp);
    end
    matchCount = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    checks++;
    if (matchPulse !== 0 || rwFlag !== 0 || expectLow !== 0) begin
      fails++;
      $display("FAIL R1: outputs in reset actual %b%b%b expected 000",
               matchPulse, rwFlag, expectLow);
    end
    rstN = 1;
    tick(); tick();

    // 7-bit mode
    addrMain = 8'h5A; maskBits = 8'hFF; tenBitMode = 0;
    curReq = "R8"; sendByte(8'h5A); tick(); expectCount("R8", 0);
    curReq = "R2"; doStart(); sendByte(8'h5A); tick(); expectCount("R2", 1);
    curReq = "R6"; doStart(); sendByte(8'h5B); tick(); expectCount("R6", 1);
    curReq = "R2"; doStart(); sendByte(8'h58); tick(); expectCount("R2", 0);
    addrMain = 8'h5B; maskBits = 8'hFE;
    doStart(); sendByte(8'h5A); tick(); expectCount("R2", 1);
    curReq = "R3"; maskBits = 8'hF0;
    doStart(); sendByte(8'h52); tick(); expectCount("R3", 1);
    doStart(); sendByte(8'h4A); tick(); expectCount("R3", 0);
    curReq = "R8"; maskBits = 8'hFF; addrMain = 8'h5A;
    doStart(); sendByte(8'h5A); sendByte(8'h5B); sendByte(8'h5A); tick();
    expectCount("R8", 1);
    curReq = "R12";
    @(negedge clk); startEv = 1; rxByte = 8'h5A; rxValid = 1; tick();
    tick(); expectCount("R12", 0);
    sendByte(8'h5A); tick(); expectCount("R12", 1);
    curReq = "R11";
    doStart(); @(negedge clk); stopEv = 1; rxByte = 8'h5A; rxValid = 1; tick();
    sendByte(8'h5A); tick(); expectCount("R11", 0);

    // 10-bit mode
    tenBitMode = 1; addrMain = 8'h06; addrLow = 8'hC3; maskBits = 8'hFF;
    curReq = "R4"; doStart(); sendByte(8'hF6); tick();
    curReq = "R5"; sendByte(8'hC3); tick(); expectCount("R5", 1);
    curReq = "R10"; doRestart(); sendByte(8'hF7); tick(); expectCount("R10", 1);
    doRestart(); sendByte(8'hF7); tick(); expectCount("R10", 1);
    doStart(); sendByte(8'hF7); tick(); expectCount("R10", 0);
    doRestart(); sendByte(8'hF7); tick(); expectCount("R10", 0);
    curReq = "R5"; doStart(); sendByte(8'hF6); sendByte(8'hC2); tick();
    expectCount("R5", 0);
    maskBits = 8'hFE; doStart(); sendByte(8'hF6); sendByte(8'hC2); tick();
    expectCount("R5", 1);
    curReq = "R11"; doStop(); doRestart(); sendByte(8'hF7); tick();
    expectCount("R11", 0);
    curReq = "R4"; maskBits = 8'hFF; addrMain = 8'hE6;
    doStart(); sendByte(8'hE6); sendByte(8'hC3); tick(); expectCount("R4", 0);
    addrMain = 8'h02; doStart(); sendByte(8'hF2); sendByte(8'hC3); tick();
    expectCount("R4", 1);
    maskBits = 8'hF9; doStart(); sendByte(8'hF4); sendByte(8'hC3); tick();
    expectCount("R4", 1);
    curReq = "R9"; maskBits = 8'hFF; doStart(); sendByte(8'hF4); sendByte(8'hC3);
    tick(); expectCount("R9", 0);
    doStart(); sendByte(8'hF2); sendByte(8'h11); sendByte(8'hC3); tick();
    expectCount("R9", 0);
    curReq = "R11"; doStart(); sendByte(8'hF2); doStop(); sendByte(8'hC3); tick();
    expectCount("R11", 0);
    curReq = "R7"; doStart(); sendByte(8'hF2); sendByte(8'hC3); tick(); tick();
    expectCount("R7", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule